// File: doc/BRIEF.md
# MDIO Management Master with Host Registers

This block is the master side of a two-wire PHY management link. A host programs it through four word-wide registers on a simple write-strobe bus with combinational readback. One register holds the target PHY address, the target register number and the read/write choice. One holds the 16 bits to send on a write. One returns the 16 bits captured on a read. The last holds an interface enable and a single status bit that starts a transaction and reports that it is in progress.

Once started, the block builds a standard 64-bit clause-22 management frame. It clocks the frame out on a divided management clock: low half first, output bits changed after the falling edge, read bits sampled on the rising edge. When the frame is done the status bit drops back to 0. The pad is controlled through a data output and a separate output enable, and the turnaround and data fields of a read are released to the PHY.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads 0, the management clock is low and the output enable is low.
- R2: Byte offset 0x7E4 is the address register, and bits 10:0 read back as written with bits 31:11 reading 0. In that register bits 4:0 are the register number, bits 9:5 are the PHY address and bit 10 is the operation (1 = read, 0 = write). Offset 0x7E8 is the write-data register, where bits 15:0 read back as written and the upper bits read 0.
- R3: Offset 0x7F0 is the control register, with the enable in bit 3 and the status in bit 0. The enable reads back as written. A write with both bit 0 and bit 3 set, made while idle, starts a transaction, and status reads 1 from the next cycle on.
- R4: A control write with bit 0 set and bit 3 clear starts nothing: status stays 0, the management clock stays low and the output enable stays low.
- R5: While busy, the management clock has a period of DIV system clocks, and each period starts with the low half. It stays low while idle. A transaction lasts exactly 64 periods.
- R6: A write frame drives, MSB first, 32 ones, then 01, then opcode 01, then the PHY address, the register number, turnaround 10 and the 16 data bits. The output enable is high for all 64 bits, and the output bit changes only at the start of a bit period.
- R7: A read frame uses opcode 10 and drives the first 46 bits. The output enable is low for the two turnaround bits and the 16 data bits.
- R8: On a read, the input is sampled in the last system cycle of the low half of bits 48 to 63. The bits are assembled MSB first and appear in bits 15:0 of the read-data register at offset 0x7EC when the transaction ends. That register changes at no other time.
- R9: Status returns to 0 exactly 64*DIV cycles after the starting write.
- R10: Register writes made during a transaction do not alter the frame in progress. A start request while busy is ignored and does not restart or extend the frame.
- R11: Writes to the read-data register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 12 | Register byte offset for writes and readback |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Readback of the register selected by host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
A bit counter or divider that is off by one shows up at the ports within one management clock period. The clock edge moves, the status bit stays up or drops a period early, or a frame field lands one bit away. A wrong latched operation shows within the first 46 bits as a wrong opcode or a dropped output enable. A sampling slip shows only when the transaction ends, as a shifted read word. Because of this, each port is compared every cycle against a timeline model, and read words are checked after every read transaction.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int HOST_AW    = 12;
  localparam int HOST_DW    = 32;

  localparam logic [HOST_AW-1:0] OFS_ADDR = 12'h7E4;
  localparam logic [HOST_AW-1:0] OFS_WDAT = 12'h7E8;
  localparam logic [HOST_AW-1:0] OFS_RDAT = 12'h7EC;
  localparam logic [HOST_AW-1:0] OFS_CTRL = 12'h7F0;

  typedef struct packed {
    logic       op_rd;
    logic [4:0] phy;
    logic [4:0] regn;
  } mgmt_target_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_target_t t, logic [15:0] data);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] body;
    opc  = t.op_rd ? 2'b10 : 2'b01;
    ta   = t.op_rd ? 2'b11 : 2'b10;
    body = t.op_rd ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, opc, t.phy, t.regn, ta, body};
  endfunction

  function automatic logic drives_bit(logic op_rd, logic [BIT_W-1:0] idx);
    return !op_rd || (int'(idx) < TA_IDX);
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          half_end;

  assign half_end = run && (cnt == LAST);
  assign rise_ev  = half_end && !mdc;
  assign fall_ev  = half_end && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (start || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  mgmt_target_t   target,
  input  logic [15:0]    wdat,
  input  logic           rise_ev,
  input  logic           fall_ev,
  input  logic           mdio_i,
  output logic           busy,
  output logic           done_ev,
  output logic           op_rd_q,
  output logic [BIT_W-1:0] bitn,
  output logic           mdio_o,
  output logic           mdio_oe,
  output logic [15:0]    cap_word
);
  logic [FRAME_BITS-1:0] frame_q;
  logic                  last_bit;

  assign last_bit = (bitn == BIT_W'(FRAME_BITS - 1));
  assign done_ev  = fall_ev && last_bit;
  assign mdio_o   = busy && frame_q[FRAME_BITS-1];
  assign mdio_oe  = busy && drives_bit(op_rd_q, bitn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= '0;
      bitn     <= '0;
      busy     <= 1'b0;
      op_rd_q  <= 1'b0;
      cap_word <= '0;
    end else if (start) begin
      frame_q <= build_frame(target, wdat);
      bitn    <= '0;
      busy    <= 1'b1;
      op_rd_q <= target.op_rd;
    end else if (busy) begin
      if (rise_ev && op_rd_q && (int'(bitn) >= DATA_IDX))
        cap_word <= {cap_word[14:0], mdio_i};
      if (fall_ev) begin
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
          bitn    <= bitn + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               busy,
  input  logic               rd_done,
  input  logic [15:0]        cap_word,
  output logic               go_ev,
  output mgmt_target_t       target,
  output logic [15:0]        wdat_q,
  output logic [15:0]        rdat_q
);
  logic [10:0] addr_q;
  logic        en_q;
  logic        ctrl_wr;

  assign ctrl_wr = host_wr && (host_addr == OFS_CTRL);
  assign go_ev   = ctrl_wr && host_wdata[0] && host_wdata[3] && !busy;
  assign target  = mgmt_target_t'(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (host_wr && host_addr == OFS_ADDR) addr_q <= host_wdata[10:0];
      if (host_wr && host_addr == OFS_WDAT) wdat_q <= host_wdata[15:0];
      if (ctrl_wr) en_q <= host_wdata[3];
      if (rd_done) rdat_q <= cap_word;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      OFS_ADDR: host_rdata[10:0] = addr_q;
      OFS_WDAT: host_rdata[15:0] = wdat_q;
      OFS_RDAT: host_rdata[15:0] = rdat_q;
      OFS_CTRL: host_rdata[3:0]  = {en_q, 2'b00, busy};
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic             go_ev;
  logic             done_ev;
  logic             rise_ev;
  logic             fall_ev;
  logic             busy;
  logic             op_rd_q;
  logic [BIT_W-1:0] bitn;
  logic [15:0]      cap_word;
  logic [15:0]      wdat_q;
  logic [15:0]      rdat_q;
  logic             rd_done;
  mgmt_target_t     target;

  assign rd_done = done_ev && op_rd_q;

  mdio_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .rd_done(rd_done), .cap_word(cap_word), .go_ev(go_ev),
    .target(target), .wdat_q(wdat_q), .rdat_q(rdat_q)
  );

  mdio_mdc_gen #(.DIV(DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .start(go_ev), .run(busy),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start(go_ev), .target(target), .wdat(wdat_q),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i), .busy(busy),
    .done_ev(done_ev), .op_rd_q(op_rd_q), .bitn(bitn), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .cap_word(cap_word)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [11:0] host_addr,
  input logic [31:0] host_wdata,
  input logic        go_ev,
  input logic        done_ev,
  input logic        fall_ev,
  input logic        busy,
  input logic        op_rd_q,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rdat_q
);
  assert_go_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_ev |=> busy);

  assert_disabled_go_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 12'h7F0 && host_wdata[0] && !host_wdata[3] && !busy) |=> !busy);

  assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_out_changes_at_bit_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_ev));

  assert_release_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(mdio_oe)) |-> $past(fall_ev));

  assert_rdata_only_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdat_q) |-> $past(done_ev && op_rd_q));

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !busy);

  assert_op_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_rd_q));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker i_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .go_ev(go_ev), .done_ev(done_ev), .fall_ev(fall_ev),
  .busy(busy), .op_rd_q(op_rd_q), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .rdat_q(rdat_q)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int TLEN = 64 * DIV;
  localparam logic [11:0] A_ADDR = 12'h7E4;
  localparam logic [11:0] A_WDAT = 12'h7E8;
  localparam logic [11:0] A_RDAT = 12'h7EC;
  localparam logic [11:0] A_CTRL = 12'h7F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [11:0] host_addr = A_CTRL;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // behavioural reference state
  logic [10:0] m_addr;
  logic [15:0] m_wdat, m_rdat, phy_data;
  logic m_en, m_busy, m_rd;
  logic [63:0] m_frame;
  int m_k;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_master #(.DIV(DIV)) i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_addr = '0; m_wdat = '0; m_rdat = '0; m_en = 0; m_busy = 0; m_rd = 0;
      m_k = 0; m_frame = '0;
    end else begin
      logic was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        m_k++;
        if (m_k == TLEN) begin
          m_busy = 0;
          if (m_rd) m_rdat = phy_data;
        end
      end
      if (host_wr) begin
        if (host_addr == A_ADDR) m_addr = host_wdata[10:0];
        if (host_addr == A_WDAT) m_wdat = host_wdata[15:0];
        if (host_addr == A_CTRL) begin
          m_en = host_wdata[3];
          if (host_wdata[0] && host_wdata[3] && !was_busy) begin
            m_busy = 1; m_k = 0; m_rd = m_addr[10];
            m_frame[63:32] = 32'hFFFF_FFFF;
            m_frame[31:30] = 2'b01;
            m_frame[29:28] = m_rd ? 2'b10 : 2'b01;
            m_frame[27:23] = m_addr[9:5];
            m_frame[22:18] = m_addr[4:0];
            m_frame[17:16] = 2'b10;
            m_frame[15:0]  = m_wdat;
          end
        end
      end
    end
  end

  // PHY side: drive read data for the released data bits
  always @(negedge clk) begin
    int idx;
    idx = m_k / DIV;
    mdio_i <= (m_busy && m_rd && idx >= 48) ? phy_data[63-idx] : 1'b1;
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_mdc, e_oe;
      int idx;
      idx   = m_k / DIV;
      e_mdc = m_busy && ((m_k % DIV) >= DIV/2);
      e_oe  = m_busy && (!m_rd || idx < 46);
      check("R5 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      check(m_rd ? "R7 oe" : "R6 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe) check("R6 mdio_o", {31'b0, mdio_o}, {31'b0, m_frame[63-idx]});
      if (host_addr == A_CTRL)
        check("R3/R9 control", host_rdata, {28'b0, m_en, 2'b00, m_busy});
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0; host_addr = A_CTRL;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    host_addr = a;
    #2 check(tag, host_rdata, exp);
    @(posedge clk); #1;
    host_addr = A_CTRL;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    phy_data = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd_check("R1 addr reg", A_ADDR, 32'h0);
    rd_check("R1 wdata reg", A_WDAT, 32'h0);
    rd_check("R1 rdata reg", A_RDAT, 32'h0);
    rd_check("R1 ctrl reg", A_CTRL, 32'h0);
    check("R1 mdc", {31'b0, mdc}, 32'h0);
    check("R1 oe", {31'b0, mdio_oe}, 32'h0);
    // R2 readback, R11 read-only
    wr(A_ADDR, 32'hFFFF_FFFF);
    rd_check("R2 addr readback", A_ADDR, 32'h0000_07FF);
    wr(A_WDAT, 32'hFFFF_ABCD);
    rd_check("R2 wdata readback", A_WDAT, 32'h0000_ABCD);
    wr(A_RDAT, 32'h0000_5555);
    rd_check("R11 rdata not writable", A_RDAT, 32'h0);
    // R4 start without enable
    wr(A_ADDR, {21'b0, 1'b0, 5'h13, 5'h0A});
    wr(A_WDAT, 32'h0000_A5C3);
    wr(A_CTRL, 32'h1);
    wait_cycles(3 * DIV);
    rd_check("R4 ignored start", A_CTRL, 32'h0);
    check("R4 mdc low", {31'b0, mdc}, 32'h0);
    // R3 enable readback
    wr(A_CTRL, 32'h8);
    rd_check("R3 enable readback", A_CTRL, 32'h8);
    // R6 write frame, with R10 disturbances mid-frame
    wr(A_CTRL, 32'h9);
    rd_check("R3 status set", A_CTRL, 32'h9);
    wait_cycles(20 * DIV);
    wr(A_ADDR, {21'b0, 1'b1, 5'h01, 5'h02});
    wr(A_WDAT, 32'h0000_0F0F);
    wr(A_CTRL, 32'h9);
    wait_cycles(TLEN);
    rd_check("R9 status clear", A_CTRL, 32'h8);
    rd_check("R10 addr updated", A_ADDR, {21'b0, 1'b1, 5'h01, 5'h02});
    // R7/R8 read phy 1 reg 2
    phy_data = 16'hC35A;
    wr(A_CTRL, 32'h9);
    wait_cycles(TLEN + 4);
    rd_check("R8 read word", A_RDAT, 32'h0000_C35A);
    // R8 boundary addresses
    wr(A_ADDR, {21'b0, 1'b1, 5'h1F, 5'h1F});
    phy_data = 16'h8001;
    wr(A_CTRL, 32'h9);
    wait_cycles(TLEN + 4);
    rd_check("R8 read word edges", A_RDAT, 32'h0000_8001);
    // R6 write with zero fields; R8 rdata kept over write
    wr(A_ADDR, 32'h0);
    wr(A_WDAT, 32'h0);
    wr(A_CTRL, 32'h9);
    wait_cycles(TLEN + 4);
    rd_check("R8 rdata held over write", A_RDAT, 32'h0000_8001);
    // R4 again after disabling
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    wait_cycles(2 * DIV);
    rd_check("R4 ignored after disable", A_CTRL, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule